// File: doc/BRIEF.md
# Configurable Host Bus Slave Port

This block lets an external host processor read and write a bank of eight 16-bit storage registers through one of four bus styles. Two static mode pins pick the style. The first pin decides how the address arrives. When it is low, the address comes on a dedicated 3-bit address bus. When it is high, the address is multiplexed onto the 16-bit data bus and captured by an address-latch strobe. The second pin decides how the transfer is qualified. When it is low, the host uses separate active-low read and write strobes. When it is high, the host uses one active-low data strobe plus a direction line.

Every host input is brought into the fast core clock domain through a two-flop synchronizer. A transfer is recognised from the synchronized combination of chip select and strobe. While a transfer is in progress the port pulls an active-low acknowledge line. For a read, it drives the data bus through an output-enable. For a write, it commits the data seen at the end of the strobe and emits a one-cycle write event carrying the register index and data. Pulses shorter than a configurable minimum are treated as glitches.

Top module: `hbp_slave_port`

## Requirements
- R1: After reset, `hd_oe` is 0, `hack_n` is 1 and all eight registers read back as 0.
- R2: With `mode_mux`=0 and `mode_ds`=0, a low pulse on `hwr_n` together with `hcs_n` low writes `hd_i` into the register selected by `haddr`. A low pulse on `hrd_n` together with `hcs_n` low returns that register on `hd_o`.
- R3: With `mode_ds`=1, a transfer is qualified by `hds_n` low with `hcs_n` low. `hrw` is sampled at the start of the transfer, and `hrw`=1 means read while `hrw`=0 means write.
- R4: With `mode_mux`=1, the register index is bits [2:0] of `hd_i` as captured on the falling edge of `hale`. Bits [15:3] of that captured address are ignored.
- R5: A transfer exists only while `hcs_n` and the active strobe are both low. A strobe without chip select, or chip select without a strobe, changes no register, raises no write event and leaves `hack_n` high.
- R6: Write data is the value on `hd_i` in the last sampled cycle before the strobe or chip select returns high. Earlier values seen during the same pulse are overwritten.
- R7: During a read, `hd_oe` is 1 and `hd_o` shows the selected register within 4 clocks of the start. `hd_oe` returns to 0 within 4 clocks after the transfer ends.
- R8: `hack_n` goes low within 4 clocks after a transfer starts and returns high within 4 clocks after it ends.
- R9: A write whose strobe stays active for fewer than MIN_PULSE sampled clocks (default 2) is ignored. A write lasting exactly MIN_PULSE clocks is accepted.
- R10: Each accepted write produces `wr_evt` high for exactly one clock, with `wr_idx` and `wr_data` giving the target and value. `hd_oe` is never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_mux | input | 1 | 1: address multiplexed on data bus; 0: separate address bus |
| mode_ds | input | 1 | 1: data strobe plus direction line; 0: separate read/write strobes |
| hcs_n | input | 1 | Host chip select, active low |
| hrd_n | input | 1 | Host read strobe, active low (mode_ds=0) |
| hwr_n | input | 1 | Host write strobe, active low (mode_ds=0) |
| hds_n | input | 1 | Host data strobe, active low (mode_ds=1) |
| hrw | input | 1 | Direction, 1 = read (mode_ds=1) |
| hale | input | 1 | Address latch strobe (mode_mux=1) |
| haddr | input | 3 | Separate register address (mode_mux=0) |
| hd_i | input | 16 | Data bus in from host; also carries address when mode_mux=1 |
| hd_o | output | 16 | Read data toward the host |
| hd_oe | output | 1 | Output enable for the data bus tristate buffer |
| hack_n | output | 1 | Acknowledge, active low while a transfer is in progress |
| wr_evt | output | 1 | One-clock write event |
| wr_idx | output | 3 | Register index of the write event |
| wr_data | output | 16 | Data of the write event |

## Verification
The bench runs every access in all four mode combinations. Reads are compared against a bench-side model of the register bank, so a swapped mode decode or a misread direction line shows up as wrong data or a write landing in the wrong register. It changes the data in the middle of a write pulse: a port that captured data at the strobe's start would store the stale word. It sets high address bits and raises a strobe without chip select. A port that decoded all sixteen address bits or ignored select would fault there. One-clock and exactly-minimum write pulses probe the glitch filter, and a wrong comparison would either accept the glitch or drop the legal write.

// File: rtl/hbp_pkg.sv
package hbp_pkg;

    localparam int unsigned HBP_DATA_W    = 16;
    localparam int unsigned HBP_NREG      = 8;
    localparam int unsigned HBP_MIN_PULSE = 2;

    typedef enum logic {
        ACC_IDLE = 1'b0,
        ACC_BUSY = 1'b1
    } acc_state_e;

    // control lines from host, in synchronizer bit order
    typedef struct packed {
        logic cs_n;
        logic rd_n;
        logic wr_n;
        logic ds_n;
        logic rw;
        logic ale;
    } host_ctl_t;

    localparam int unsigned HOST_CTL_W = $bits(host_ctl_t);
    localparam logic [HOST_CTL_W-1:0] HOST_CTL_IDLE = 6'b111100;

    function automatic logic strobe_on(input host_ctl_t c, input logic ds_mode);
        if (ds_mode) begin
            return !c.ds_n;
        end
        return !c.rd_n || !c.wr_n;
    endfunction

    function automatic logic dir_is_read(input host_ctl_t c, input logic ds_mode);
        if (ds_mode) begin
            return c.rw;
        end
        return !c.rd_n;
    endfunction

endpackage

// File: rtl/hbp_sync.sv
module hbp_sync #(
    parameter int unsigned          W       = 1,
    parameter logic [W-1:0]         RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/hbp_frontend.sv
module hbp_frontend
    import hbp_pkg::*;
#(
    parameter int unsigned IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_mux,
    input  logic             mode_ds,
    input  host_ctl_t        ctl_s,
    input  logic [IDX_W-1:0] addr_s,
    input  logic [IDX_W-1:0] bus_low_s,
    output logic             act,
    output logic             is_read,
    output logic [IDX_W-1:0] idx
);
    logic             ale_q;
    logic [IDX_W-1:0] lat_idx;
    logic             ale_fall;

    assign ale_fall = ale_q && !ctl_s.ale;

    always_ff @(posedge clk) begin
        if (rst) begin
            ale_q   <= 1'b0;
            lat_idx <= '0;
        end else begin
            ale_q <= ctl_s.ale;
            if (ale_fall) begin
                lat_idx <= bus_low_s;
            end
        end
    end

    always_comb begin
        act     = !ctl_s.cs_n && strobe_on(ctl_s, mode_ds);
        is_read = dir_is_read(ctl_s, mode_ds);
        idx     = mode_mux ? lat_idx : addr_s;
    end
endmodule

// File: rtl/hbp_access.sv
module hbp_access
    import hbp_pkg::*;
#(
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned IDX_W     = 3,
    parameter int unsigned MIN_PULSE = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              act,
    input  logic              is_read_in,
    input  logic [IDX_W-1:0]  idx_in,
    input  logic [DATA_W-1:0] data_in,
    output logic              busy,
    output logic              rd_drive,
    output logic [IDX_W-1:0]  cur_idx,
    output logic              wr_evt,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [DATA_W-1:0] wr_data
);
    localparam int unsigned CNT_W   = $clog2(MIN_PULSE + 1) + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_MIN = CNT_W'(MIN_PULSE);

    acc_state_e        state;
    logic [CNT_W-1:0]  cnt;
    logic              dir_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] dat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ACC_IDLE;
            cnt     <= '0;
            dir_q   <= 1'b0;
            idx_q   <= '0;
            dat_q   <= '0;
            wr_evt  <= 1'b0;
            wr_idx  <= '0;
            wr_data <= '0;
        end else begin
            wr_evt <= 1'b0;
            unique case (state)
                ACC_IDLE: begin
                    if (act) begin
                        state <= ACC_BUSY;
                        cnt   <= CNT_W'(1);
                        dir_q <= is_read_in;
                        idx_q <= idx_in;
                        dat_q <= data_in;
                    end
                end
                ACC_BUSY: begin
                    if (act) begin
                        if (cnt != CNT_MAX) begin
                            cnt <= cnt + CNT_W'(1);
                        end
                        dat_q <= data_in;
                    end else begin
                        state <= ACC_IDLE;
                        if (!dir_q && cnt >= CNT_MIN) begin
                            wr_evt  <= 1'b1;
                            wr_idx  <= idx_q;
                            wr_data <= dat_q;
                        end
                    end
                end
                default: state <= ACC_IDLE;
            endcase
        end
    end

    assign busy     = (state == ACC_BUSY);
    assign rd_drive = busy && dir_q;
    assign cur_idx  = idx_q;
endmodule

// File: rtl/hbp_regbank.sv
module hbp_regbank #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned NREG   = 8,
    parameter int unsigned IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= '0;
            end else if (we && widx == IDX_W'(g)) begin
                regs[g] <= wdata;
            end
        end
    end

    assign rdata = regs[ridx];
endmodule

// File: rtl/hbp_slave_port.sv
module hbp_slave_port
    import hbp_pkg::*;
#(
    parameter int unsigned DATA_W    = HBP_DATA_W,
    parameter int unsigned NREG      = HBP_NREG,
    parameter int unsigned MIN_PULSE = HBP_MIN_PULSE,
    localparam int unsigned IDX_W    = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_mux,
    input  logic              mode_ds,
    input  logic              hcs_n,
    input  logic              hrd_n,
    input  logic              hwr_n,
    input  logic              hds_n,
    input  logic              hrw,
    input  logic              hale,
    input  logic [IDX_W-1:0]  haddr,
    input  logic [DATA_W-1:0] hd_i,
    output logic [DATA_W-1:0] hd_o,
    output logic              hd_oe,
    output logic              hack_n,
    output logic              wr_evt,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [DATA_W-1:0] wr_data
);
    host_ctl_t              ctl_raw;
    logic [HOST_CTL_W-1:0]  ctl_sv;
    host_ctl_t              ctl_s;
    logic [IDX_W-1:0]       addr_s;
    logic [DATA_W-1:0]      data_s;

    logic                   acc_act;
    logic                   fe_read;
    logic [IDX_W-1:0]       fe_idx;
    logic                   busy;
    logic                   rd_drive;
    logic [IDX_W-1:0]       cur_idx;
    logic [DATA_W-1:0]      rdata;

    assign ctl_raw = '{cs_n: hcs_n, rd_n: hrd_n, wr_n: hwr_n,
                       ds_n: hds_n, rw: hrw, ale: hale};

    hbp_sync #(.W(HOST_CTL_W), .RST_VAL(HOST_CTL_IDLE)) u_sync_ctl (
        .clk(clk), .rst(rst), .d(ctl_raw), .q(ctl_sv)
    );
    hbp_sync #(.W(IDX_W), .RST_VAL('0)) u_sync_addr (
        .clk(clk), .rst(rst), .d(haddr), .q(addr_s)
    );
    hbp_sync #(.W(DATA_W), .RST_VAL('0)) u_sync_data (
        .clk(clk), .rst(rst), .d(hd_i), .q(data_s)
    );

    assign ctl_s = host_ctl_t'(ctl_sv);

    hbp_frontend #(.IDX_W(IDX_W)) u_fe (
        .clk(clk), .rst(rst),
        .mode_mux(mode_mux), .mode_ds(mode_ds),
        .ctl_s(ctl_s), .addr_s(addr_s), .bus_low_s(data_s[IDX_W-1:0]),
        .act(acc_act), .is_read(fe_read), .idx(fe_idx)
    );

    hbp_access #(.DATA_W(DATA_W), .IDX_W(IDX_W), .MIN_PULSE(MIN_PULSE)) u_acc (
        .clk(clk), .rst(rst),
        .act(acc_act), .is_read_in(fe_read), .idx_in(fe_idx), .data_in(data_s),
        .busy(busy), .rd_drive(rd_drive), .cur_idx(cur_idx),
        .wr_evt(wr_evt), .wr_idx(wr_idx), .wr_data(wr_data)
    );

    hbp_regbank #(.DATA_W(DATA_W), .NREG(NREG), .IDX_W(IDX_W)) u_bank (
        .clk(clk), .rst(rst),
        .we(wr_evt), .widx(wr_idx), .wdata(wr_data),
        .ridx(cur_idx), .rdata(rdata)
    );

    assign hd_oe  = rd_drive;
    assign hd_o   = rd_drive ? rdata : '0;
    assign hack_n = !busy;
endmodule

// File: rtl/hbp_slave_port_chk.sv
module hbp_slave_port_chk (
    input logic clk,
    input logic rst,
    input logic hd_oe,
    input logic hack_n,
    input logic wr_evt,
    input logic act
);
    // R1: first cycle out of reset is idle
    p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!hd_oe && hack_n));

    // R7: bus driven only inside an acknowledged transfer
    p_oe_inside_ack_r7: assert property (@(posedge clk) disable iff (rst)
        hd_oe |-> !hack_n);

    // R8: acknowledge released one cycle after the synchronized transfer drops
    p_ack_release_r8: assert property (@(posedge clk) disable iff (rst)
        (!hack_n && !act) |=> hack_n);

    // R10: write event is a single-cycle pulse
    p_wr_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        wr_evt |=> !wr_evt);

    // R10: write event follows an acknowledged transfer
    p_wr_after_ack_r10: assert property (@(posedge clk) disable iff (rst)
        wr_evt |-> $past(!hack_n));

    // R10: no bus drive while a write commits
    p_wr_no_drive_r10: assert property (@(posedge clk) disable iff (rst)
        wr_evt |-> !hd_oe);
endmodule

bind hbp_slave_port hbp_slave_port_chk u_chk (
    .clk(clk), .rst(rst), .hd_oe(hd_oe), .hack_n(hack_n),
    .wr_evt(wr_evt), .act(acc_act)
);

// File: tb/hbp_slave_port_bench.sv
module hbp_slave_port_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_mux = 1'b0, mode_ds = 1'b0;
    logic        hcs_n = 1'b1, hrd_n = 1'b1, hwr_n = 1'b1, hds_n = 1'b1;
    logic        hrw = 1'b0, hale = 1'b0;
    logic [2:0]  haddr = '0;
    logic [15:0] hd_i = '0;
    logic [15:0] hd_o;
    logic        hd_oe, hack_n, wr_evt;
    logic [2:0]  wr_idx;
    logic [15:0] wr_data;

    int          checks = 0;
    int          errors = 0;
    int          evt_n = 0;
    logic [2:0]  evt_idx;
    logic [15:0] evt_dat;
    logic [15:0] model [8];
    bit          done = 1'b0;

    localparam int MIN_PULSE = 2;

    always #5 clk = ~clk;

    hbp_slave_port u_hbp_slave_port (
        .clk(clk), .rst(rst), .mode_mux(mode_mux), .mode_ds(mode_ds),
        .hcs_n(hcs_n), .hrd_n(hrd_n), .hwr_n(hwr_n), .hds_n(hds_n),
        .hrw(hrw), .hale(hale), .haddr(haddr), .hd_i(hd_i),
        .hd_o(hd_o), .hd_oe(hd_oe), .hack_n(hack_n),
        .wr_evt(wr_evt), .wr_idx(wr_idx), .wr_data(wr_data)
    );

    always @(negedge clk) begin
        if (!rst && wr_evt) begin
            evt_n   = evt_n + 1;
            evt_idx = wr_idx;
            evt_dat = wr_data;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic bit write_lands(input int width);
        return width >= MIN_PULSE;
    endfunction

    // one host transfer; d1 first, d2 driven in the last strobe cycle
    task automatic access(input bit mux, input bit ds, input bit rd, input logic [2:0] idx,
                          input logic [15:0] d1, input logic [15:0] d2, input int width,
                          input string req);
        int ev0;
        ev0 = evt_n;
        @(negedge clk);
        mode_mux = mux;
        mode_ds  = ds;
        if (mux) begin
            hd_i = {13'($urandom), idx};
            hale = 1'b1;
            repeat (2) @(negedge clk);
            hale = 1'b0;
            repeat (2) @(negedge clk);
        end else begin
            haddr = idx;
        end
        hrw   = rd;
        hd_i  = rd ? 16'h0 : d1;
        @(negedge clk);
        hcs_n = 1'b0;
        if (ds) hds_n = 1'b0;
        else if (rd) hrd_n = 1'b0;
        else hwr_n = 1'b0;
        for (int c = 1; c <= width; c++) begin
            @(negedge clk);
            if (!rd && c == width - 1) hd_i = d2;
            if (c == 4) begin
                chk(hack_n == 1'b0, {req, " R8 ack low"}, hack_n, 0);
                if (rd) begin
                    chk(hd_oe == 1'b1, {req, " R7 oe"}, hd_oe, 1);
                    chk(hd_o == model[idx], {req, " R7 read data"}, hd_o, model[idx]);
                end
            end
        end
        hrd_n = 1'b1; hwr_n = 1'b1; hds_n = 1'b1;
        repeat (2) @(negedge clk);
        hcs_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(hack_n == 1'b1, {req, " R8 ack release"}, hack_n, 1);
        chk(hd_oe == 1'b0, {req, " R7 oe release"}, hd_oe, 0);
        if (!rd) begin
            if (write_lands(width)) begin
                model[idx] = d2;
                chk(evt_n == ev0 + 1, {req, " R10 one event"}, evt_n - ev0, 1);
                chk(evt_idx == idx && evt_dat == d2, {req, " R10 event fields"},
                    {13'h0, evt_idx, evt_dat}, {13'h0, idx, d2});
            end else begin
                chk(evt_n == ev0, {req, " R9 short pulse no event"}, evt_n - ev0, 0);
            end
        end
    endtask

    task automatic rd(input bit mux, input bit ds, input logic [2:0] idx, input string req);
        access(mux, ds, 1'b1, idx, 16'h0, 16'h0, 5, req);
    endtask

    task automatic wr(input bit mux, input bit ds, input logic [2:0] idx,
                      input logic [15:0] d, input int width, input string req);
        access(mux, ds, 1'b0, idx, d, d, width, req);
    endtask

    initial begin
        int ev0;
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 8; i++) model[i] = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(hd_oe == 1'b0, "R1 oe after reset", hd_oe, 0);
        chk(hack_n == 1'b1, "R1 ack after reset", hack_n, 1);
        for (int i = 0; i < 8; i++) rd(1'b0, 1'b0, 3'(i), "R1 zero regs");

        // R2 separate address, separate strobes
        wr(1'b0, 1'b0, 3'd3, 16'hA5C3, 5, "R2");
        rd(1'b0, 1'b0, 3'd3, "R2");
        // R3 data strobe plus direction
        wr(1'b0, 1'b1, 3'd5, 16'h1234, 6, "R3");
        rd(1'b0, 1'b1, 3'd5, "R3");
        rd(1'b0, 1'b0, 3'd3, "R3 other reg untouched");
        // R4 multiplexed address, both strobe styles
        wr(1'b1, 1'b0, 3'd6, 16'hBEEF, 5, "R4");
        rd(1'b1, 1'b1, 3'd6, "R4");
        wr(1'b1, 1'b1, 3'd1, 16'h0F0F, 5, "R4");
        rd(1'b1, 1'b0, 3'd1, "R4");

        // R5 strobe without chip select
        ev0 = evt_n;
        @(negedge clk);
        mode_mux = 1'b0; mode_ds = 1'b0; haddr = 3'd3; hd_i = 16'hDEAD;
        hwr_n = 1'b0;
        repeat (6) @(negedge clk);
        chk(hack_n == 1'b1, "R5 no ack without select", hack_n, 1);
        hwr_n = 1'b1;
        // R5 select without strobe
        hcs_n = 1'b0;
        repeat (6) @(negedge clk);
        chk(hack_n == 1'b1, "R5 no ack without strobe", hack_n, 1);
        hcs_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(evt_n == ev0, "R5 no write event", evt_n - ev0, 0);
        rd(1'b0, 1'b0, 3'd3, "R5 reg unchanged");

        // R6 data changed within pulse: last value wins
        access(1'b0, 1'b0, 1'b0, 3'd2, 16'h1111, 16'h2222, 6, "R6");
        rd(1'b0, 1'b0, 3'd2, "R6");
        access(1'b1, 1'b1, 1'b0, 3'd7, 16'h3333, 16'h4444, 5, "R6 mux ds");
        rd(1'b0, 1'b1, 3'd7, "R6 mux ds");

        // R9 glitch below minimum and exactly at minimum
        wr(1'b0, 1'b0, 3'd4, 16'h7777, 1, "R9 one clock");
        rd(1'b0, 1'b0, 3'd4, "R9 glitch ignored");
        wr(1'b0, 1'b1, 3'd4, 16'h8888, MIN_PULSE, "R9 min width");
        rd(1'b0, 1'b0, 3'd4, "R9 min accepted");

        // random mix, all modes (R2 R3 R4 R10)
        for (int n = 0; n < 60; n++) begin
            bit mx, dsm, isrd;
            logic [2:0] ix;
            logic [15:0] dv;
            int w;
            mx   = 1'($urandom);
            dsm  = 1'($urandom);
            isrd = 1'($urandom);
            ix   = 3'($urandom);
            dv   = 16'($urandom);
            w    = 4 + int'($urandom % 5);
            if (isrd) rd(mx, dsm, ix, "R2 R3 R4 random read");
            else      wr(mx, dsm, ix, dv, w, "R10 random write");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule